// File: doc/BRIEF.md
# Integer ALU with Latched Compare Flags

This block executes the three-operand integer operations of a small processor core: add, subtract, multiply, unsigned divide and remainder, bitwise AND and OR. It also holds two status bits, an equal flag and a below flag. A compare operation loads these flags. It writes no register. A later condition operation converts the stored flags into a 0 or 1 value for a destination register.

The pipeline offers an operation with `in_valid`, the opcode, the destination register index and up to three operand values. All operations except divide and remainder produce their result one cycle after acceptance. Divide and remainder run on a restoring divider that takes one quotient bit per cycle, and `busy` stays high while it works. A zero divisor does not start the divider. It returns a trap pulse with no register write. The register file sits outside the block. The block protects register 0 by never raising `wr_en` for destination index 0.

Top module: `flag_alu`

## Requirements
- R1: Opcodes 0 (add), 1 (subtract), 2 (multiply), 5 (AND) and 6 (OR) produce `opnd_b op opnd_c`, truncated to DATA_W bits, on `res_data` with `res_valid` and `wr_en` high one cycle after the operation is accepted.
- R2: Opcode 3 returns the unsigned quotient and opcode 4 the unsigned remainder of `opnd_b` by `opnd_c`. `busy` rises after acceptance and `res_valid` comes DATA_W cycles after the accepting edge, together with `wr_en`.
- R3: When opcode 3 or 4 has a zero `opnd_c`, the block pulses `trap_div0` with `res_valid` one cycle after acceptance, keeps `wr_en` low, drives `res_data` to 0 and does not become busy.
- R4: Opcode 7 (compare) sets the equal flag to (`opnd_a == opnd_b`) and the below flag to (`opnd_a < opnd_b`, unsigned). It returns `res_valid` with `wr_en` low and `res_data` 0.
- R5: Condition opcodes write a 0/1 value: 8 gives equal, 9 gives not equal, 10 gives below, 11 gives equal or below, 12 gives not below, 13 gives neither equal nor below.
- R6: Both flags are 0 after reset. Only an accepted compare changes them.
- R7: When the destination index `in_dst` is 0, `wr_en` stays low and `res_valid` and `res_data` behave as for any other destination.
- R8: An operation offered while `busy` is high is ignored. It gives no result and does not change the flags.
- R9: Opcodes 14 and 15 return `res_valid` with `wr_en` and `trap_div0` low, `res_data` 0, and the flags unchanged.
- R10: During and right after reset, `res_valid`, `wr_en`, `trap_div0` and `busy` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation offered this cycle |
| in_op | input | 4 | Opcode |
| in_dst | input | 5 | Destination register index |
| opnd_a | input | DATA_W | Compare left operand |
| opnd_b | input | DATA_W | First source operand |
| opnd_c | input | DATA_W | Second source operand |
| busy | output | 1 | Divider occupied; new operations are ignored |
| res_valid | output | 1 | Result or completion pulse |
| res_data | output | DATA_W | Result value |
| wr_en | output | 1 | Write `res_data` to the destination register |
| trap_div0 | output | 1 | Divide-by-zero trap pulse |

## Verification
The bench builds the block with DATA_W = 8. At that width add, subtract and multiply wrap around after small operand values. A compare with a top-bit-set operand tells unsigned ordering apart from signed ordering. Each divide finishes in eight cycles, so the bench can count the divider latency exactly and can offer an operation during the busy window to check that it is ignored.

// File: rtl/flag_alu_pkg.sv
package flag_alu_pkg;

  typedef enum logic [3:0] {
    OP_ADD = 4'd0,
    OP_SUB = 4'd1,
    OP_MUL = 4'd2,
    OP_DIV = 4'd3,
    OP_REM = 4'd4,
    OP_AND = 4'd5,
    OP_OR  = 4'd6,
    OP_CMP = 4'd7,
    OP_CEQ = 4'd8,
    OP_CNE = 4'd9,
    OP_CLT = 4'd10,
    OP_CLE = 4'd11,
    OP_CGE = 4'd12,
    OP_CGT = 4'd13
  } alu_op_e;

  function automatic logic op_is_divide(input logic [3:0] op);
    return (op == OP_DIV) || (op == OP_REM);
  endfunction

  function automatic logic op_is_cond(input logic [3:0] op);
    return (op >= OP_CEQ) && (op <= OP_CGT);
  endfunction

endpackage

// File: rtl/flag_alu_flags.sv
module flag_alu_flags #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmp_fire,
  input  logic [DATA_W-1:0] lhs,
  input  logic [DATA_W-1:0] rhs,
  output logic              flag_eq,
  output logic              flag_lt
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_eq <= 1'b0;
      flag_lt <= 1'b0;
    end else if (cmp_fire) begin
      flag_eq <= (lhs == rhs);
      flag_lt <= (lhs < rhs);
    end
  end

  assert_flags_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !cmp_fire |=> $stable({flag_eq, flag_lt}));

endmodule

// File: rtl/flag_alu_datapath.sv
module flag_alu_datapath
  import flag_alu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [3:0]        op,
  input  logic [DATA_W-1:0] b,
  input  logic [DATA_W-1:0] c,
  input  logic              flag_eq,
  input  logic              flag_lt,
  output logic [DATA_W-1:0] value,
  output logic              writes
);

  localparam int PROD_W = 2 * DATA_W;

  function automatic logic [DATA_W-1:0] low_product(input logic [DATA_W-1:0] x,
                                                    input logic [DATA_W-1:0] y);
    logic [PROD_W-1:0] full;
    full = PROD_W'(x) * PROD_W'(y);
    return full[DATA_W-1:0];
  endfunction

  function automatic logic cond_bit(input logic [3:0] code, input logic eq, input logic lt);
    case (code)
      OP_CEQ:  return eq;
      OP_CNE:  return !eq;
      OP_CLT:  return lt;
      OP_CLE:  return eq | lt;
      OP_CGE:  return !lt;
      OP_CGT:  return !eq & !lt;
      default: return 1'b0;
    endcase
  endfunction

  always_comb begin
    value  = '0;
    writes = 1'b1;
    case (op)
      OP_ADD:  value = b + c;
      OP_SUB:  value = b - c;
      OP_MUL:  value = low_product(b, c);
      OP_AND:  value = b & c;
      OP_OR:   value = b | c;
      OP_CEQ, OP_CNE, OP_CLT, OP_CLE, OP_CGE, OP_CGT:
               value = DATA_W'(cond_bit(op, flag_eq, flag_lt));
      default: writes = 1'b0;
    endcase
  end

endmodule

// File: rtl/flag_alu_divider.sv
module flag_alu_divider #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              want_rem,
  input  logic [DATA_W-1:0] dividend,
  input  logic [DATA_W-1:0] divisor,
  output logic              busy,
  output logic              last,
  output logic [DATA_W-1:0] result
);

  localparam int CNT_W = $clog2(DATA_W + 1);

  logic [DATA_W-1:0] rem_q, quo_q, dvs_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              mod_q;

  logic [DATA_W:0]   shifted, diff;
  logic              fits;
  logic [DATA_W-1:0] rem_n, quo_n;

  always_comb begin
    shifted = {rem_q, quo_q[DATA_W-1]};
    diff    = shifted - {1'b0, dvs_q};
    fits    = !diff[DATA_W];
    rem_n   = fits ? diff[DATA_W-1:0] : shifted[DATA_W-1:0];
    quo_n   = {quo_q[DATA_W-2:0], fits};
  end

  assign last   = busy && (cnt_q == CNT_W'(1));
  assign result = mod_q ? rem_n : quo_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      rem_q <= '0;
      quo_q <= '0;
      dvs_q <= '0;
      cnt_q <= '0;
      mod_q <= 1'b0;
    end else if (start) begin
      busy  <= 1'b1;
      rem_q <= '0;
      quo_q <= dividend;
      dvs_q <= divisor;
      cnt_q <= CNT_W'(DATA_W);
      mod_q <= want_rem;
    end else if (busy) begin
      rem_q <= rem_n;
      quo_q <= quo_n;
      cnt_q <= cnt_q - CNT_W'(1);
      if (last) busy <= 1'b0;
    end
  end

  assert_no_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !start);

  assert_last_frees_R2: assert property (@(posedge clk) disable iff (!rst_n)
    last |=> !busy);

  assert_start_busies_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy);

endmodule

// File: rtl/flag_alu.sv
module flag_alu
  import flag_alu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [3:0]        in_op,
  input  logic [4:0]        in_dst,
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  input  logic [DATA_W-1:0] opnd_c,
  output logic              busy,
  output logic              res_valid,
  output logic [DATA_W-1:0] res_data,
  output logic              wr_en,
  output logic              trap_div0
);

  logic              accept, is_divop, div_zero, div_start, cmp_fire;
  logic              flag_eq, flag_lt;
  logic [DATA_W-1:0] dp_value;
  logic              dp_writes;
  logic              div_last;
  logic [DATA_W-1:0] div_result;
  logic [4:0]        dst_q;

  assign accept    = in_valid && !busy;
  assign is_divop  = op_is_divide(in_op);
  assign div_zero  = accept && is_divop && (opnd_c == '0);
  assign div_start = accept && is_divop && (opnd_c != '0);
  assign cmp_fire  = accept && (in_op == OP_CMP);

  flag_alu_flags #(.DATA_W(DATA_W)) u_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmp_fire (cmp_fire),
    .lhs      (opnd_a),
    .rhs      (opnd_b),
    .flag_eq  (flag_eq),
    .flag_lt  (flag_lt)
  );

  flag_alu_datapath #(.DATA_W(DATA_W)) u_dp (
    .op      (in_op),
    .b       (opnd_b),
    .c       (opnd_c),
    .flag_eq (flag_eq),
    .flag_lt (flag_lt),
    .value   (dp_value),
    .writes  (dp_writes)
  );

  flag_alu_divider #(.DATA_W(DATA_W)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (div_start),
    .want_rem (in_op == OP_REM),
    .dividend (opnd_b),
    .divisor  (opnd_c),
    .busy     (busy),
    .last     (div_last),
    .result   (div_result)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_data  <= '0;
      wr_en     <= 1'b0;
      trap_div0 <= 1'b0;
      dst_q     <= '0;
    end else begin
      res_valid <= 1'b0;
      wr_en     <= 1'b0;
      trap_div0 <= 1'b0;
      if (div_start) dst_q <= in_dst;
      if (div_last) begin
        res_valid <= 1'b1;
        res_data  <= div_result;
        wr_en     <= (dst_q != 5'd0);
      end else if (div_zero) begin
        res_valid <= 1'b1;
        res_data  <= '0;
        trap_div0 <= 1'b1;
      end else if (accept && !is_divop) begin
        res_valid <= 1'b1;
        res_data  <= dp_writes ? dp_value : '0;
        wr_en     <= dp_writes && (in_dst != 5'd0);
      end
    end
  end

  assert_single_cycle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !is_divop) |=> res_valid);

  assert_div0_trap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    div_zero |=> (res_valid && trap_div0 && !wr_en && !busy));

  assert_trap_no_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    trap_div0 |-> !wr_en);

  assert_cmp_no_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_fire |=> (res_valid && !wr_en));

  assert_cond_binary_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && op_is_cond(in_op)) |=> (res_data[DATA_W-1:1] == '0));

  assert_r0_discard_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !is_divop && in_dst == 5'd0) |=> !wr_en);

  assert_write_needs_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en || trap_div0) |-> res_valid);

endmodule

// File: tb/test_flag_alu.sv
module test_flag_alu;

  localparam int W = 8;
  localparam logic [W-1:0] MASK = '1;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [3:0]   in_op = '0;
  logic [4:0]   in_dst = '0;
  logic [W-1:0] opnd_a = '0, opnd_b = '0, opnd_c = '0;
  logic         busy, res_valid, wr_en, trap_div0;
  logic [W-1:0] res_data;

  flag_alu #(.DATA_W(W)) i_flag_alu (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op), .in_dst(in_dst),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .opnd_c(opnd_c), .busy(busy),
    .res_valid(res_valid), .res_data(res_data), .wr_en(wr_en), .trap_div0(trap_div0)
  );

  always #10 clk = ~clk;

  typedef struct {
    logic [W-1:0] data;
    logic         wr;
    logic         trap;
    string        req;
  } exp_t;

  exp_t q[$];
  int   n_checks = 0;
  int   n_err = 0;
  bit   ref_eq = 0, ref_lt = 0;
  bit   finished = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic wrap_up();
    if (!finished) begin
      finished = 1;
      $display("  Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
    end
  endtask

  // monitor: pops expected results as the design produces them
  always @(negedge clk) begin
    if (rst_n && res_valid) begin
      if (q.size() == 0) begin
        check(0, "R8", "unexpected result", 1, 0);
      end else begin
        exp_t e;
        e = q.pop_front();
        check(res_data == e.data, e.req, "res_data", res_data, e.data);
        check(wr_en == e.wr, e.req, "wr_en", wr_en, e.wr);
        check(trap_div0 == e.trap, e.req, "trap_div0", trap_div0, e.trap);
      end
    end
  end

  // reference model, written independently of the RTL
  function automatic exp_t predict(input int op, input int dst, input int a,
                                   input int b, input int c, input string req);
    exp_t e;
    int unsigned v;
    bit writes;
    writes = 1; v = 0; e.trap = 0; e.req = req;
    case (op)
      0: v = b + c;
      1: v = b - c;
      2: v = b * c;
      3: if (c == 0) begin e.trap = 1; writes = 0; end else v = b / c;
      4: if (c == 0) begin e.trap = 1; writes = 0; end else v = b % c;
      5: v = b & c;
      6: v = b | c;
      7: begin ref_eq = (a == b); ref_lt = (a < b); writes = 0; end
      8: v = ref_eq;
      9: v = !ref_eq;
      10: v = ref_lt;
      11: v = ref_eq || ref_lt;
      12: v = !ref_lt;
      13: v = !ref_eq && !ref_lt;
      default: writes = 0;
    endcase
    e.data = writes ? W'(v & MASK) : '0;
    e.wr   = writes && (dst != 0);
    return e;
  endfunction

  // driver: waits for the block to be free, offers one operation, pushes the expectation
  task automatic issue(input int op, input int dst, input int a, input int b,
                       input int c, input string req);
    while (busy) @(negedge clk);
    q.push_back(predict(op, dst, a, b, c, req));
    in_op = 4'(op); in_dst = 5'(dst);
    opnd_a = W'(a); opnd_b = W'(b); opnd_c = W'(c);
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    #(20 * 200000);
    check(0, "R10", "watchdog expired", 0, 1);
    wrap_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!res_valid && !wr_en && !trap_div0 && !busy, "R10", "outputs in reset",
          {res_valid, wr_en, trap_div0, busy}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!res_valid && !busy, "R10", "outputs after reset", {res_valid, busy}, 0);

    // R6: flags are zero before any compare
    issue(9, 1, 0, 0, 0, "R6");
    issue(12, 1, 0, 0, 0, "R6");
    issue(10, 1, 0, 0, 0, "R6");

    // R1: wrapping arithmetic and logic, single-cycle latency
    issue(0, 3, 0, 200, 100, "R1");
    check(res_valid == 1, "R1", "latency one cycle", res_valid, 1);
    issue(1, 3, 0, 5, 9, "R1");
    issue(2, 4, 0, 20, 13, "R1");
    issue(5, 5, 0, 8'hF0, 8'h3C, "R1");
    issue(6, 6, 0, 8'hF0, 8'h0F, "R1");
    issue(0, 7, 0, 255, 255, "R1");

    // R2: divide and remainder with latency count
    issue(3, 8, 0, 200, 7, "R2");
    check(!res_valid && busy, "R2", "busy after divide start", {res_valid, busy}, 1);
    for (int k = 1; k <= W; k++) begin
      @(negedge clk);
      if (k < W) check(!res_valid, "R2", "divide result early", k, W);
      else check(res_valid && !busy, "R2", "divide result at DATA_W", res_valid, 1);
    end
    issue(4, 8, 0, 200, 7, "R2");
    issue(3, 9, 0, 255, 1, "R2");
    issue(3, 9, 0, 3, 200, "R2");
    issue(4, 9, 0, 3, 200, "R2");
    issue(4, 9, 0, 255, 16, "R2");

    // R3: zero divisor traps
    issue(3, 10, 0, 77, 0, "R3");
    check(!busy, "R3", "no busy on zero divisor", busy, 0);
    issue(4, 10, 0, 77, 0, "R3");

    // R4 / R5: equal, below, and unsigned above with top bit set
    issue(7, 1, 5, 5, 0, "R4");
    for (int op = 8; op <= 13; op++) issue(op, 2, 0, 0, 0, "R5");
    issue(7, 1, 3, 9, 0, "R4");
    for (int op = 8; op <= 13; op++) issue(op, 2, 0, 0, 0, "R5");
    issue(7, 1, 200, 9, 0, "R4");
    for (int op = 8; op <= 13; op++) issue(op, 2, 0, 0, 0, "R5");

    // R6: ordinary ops leave flags alone
    issue(7, 1, 4, 4, 0, "R6");
    issue(0, 2, 0, 1, 1, "R6");
    issue(3, 2, 0, 9, 3, "R6");
    issue(8, 2, 0, 0, 0, "R6");

    // R7: destination 0 never written
    issue(0, 0, 0, 10, 20, "R7");
    issue(8, 0, 0, 0, 0, "R7");
    issue(3, 0, 0, 100, 10, "R7");

    // R8: operation offered while busy is ignored
    issue(3, 11, 0, 250, 3, "R8");
    in_op = 4'd7; opnd_a = 8'd1; opnd_b = 8'd2; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    issue(8, 12, 0, 0, 0, "R8");
    issue(10, 12, 0, 0, 0, "R8");

    // R9: unused opcodes
    issue(14, 13, 9, 9, 9, "R9");
    issue(15, 13, 1, 2, 3, "R9");
    issue(8, 13, 0, 0, 0, "R9");
    issue(10, 13, 0, 0, 0, "R9");

    repeat (W + 4) @(negedge clk);
    check(q.size() == 0, "R8", "results outstanding", q.size(), 0);
    wrap_up();
  end

endmodule